// File: doc/BRIEF.md
# Double-Buffered Input Capture Unit

This unit records the value of a free-running count at the moment an edge event arrives. Two timers share one count bus in alternating time slots. Each slot is marked by its own strobe, and a configuration bit picks which timer supplies the captured value. An event that lands in the other timer's slot is held until the next slot of the chosen timer. The capture is then taken from the bus in that cycle.

Captured values pass through two stages. A capture always writes the secondary (holding) register. The primary register is the one software reads, and it is refilled from the secondary register only after software has read it. The primary register holds no meaningful value until two captures have occurred after reset. The first capture fills the holding register, and the second capture shifts that first value into the primary register. A capture that overwrites a holding value which has not yet moved forward sets a sticky overrun flag.

Top module: `cap_unit`

## Requirements
- R1: Reset (rst_n low) clears the primary register, the secondary register and the overrun flag to 0, and clears any pending event, so the start-up rule of R5 applies again.
- R2: With src_sel = 0 a capture is taken only in a cycle where slot_a is high, and with src_sel = 1 only in a cycle where slot_b is high. The value captured is cnt_bus in that cycle.
- R3: A capture writes cnt_bus into the secondary register, and the new value is visible on sec_val in the cycle after the capture cycle. Without a capture, sec_val keeps its value.
- R4: An event arriving in a cycle where the selected strobe is low leaves sec_val unchanged. The event is held pending and captured in the next cycle in which the selected strobe is high.
- R5: After reset, the first capture loads only the secondary register and prim_val stays 0. The second capture moves the first captured value into the primary register at the same clock edge at which it loads the new value into the secondary register.
- R6: Once the primary register is loaded, later captures leave prim_val unchanged until a read strobe occurs.
- R7: A read strobe (rd_stb high for one cycle) while the secondary register holds a value not yet moved forward copies that value into the primary register at the clock edge that ends the strobe cycle. A read strobe while no such value is held arms the transfer, which then happens at the clock edge after the next capture.
- R8: A capture that overwrites a secondary value not yet moved forward, with no transfer at the same edge, replaces that value and sets overrun to 1. overrun stays at 1 until reset.
- R9: A capture and a transfer at the same clock edge move the old secondary value into the primary register, load the new count into the secondary register, and do not set overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_bus | input | CNT_W | Count bus, shared by the two timers in alternate slots |
| slot_a | input | 1 | High in the cycles where cnt_bus carries timer A's count |
| slot_b | input | 1 | High in the cycles where cnt_bus carries timer B's count |
| src_sel | input | 1 | Source timer for captures: 0 = timer A, 1 = timer B |
| evt | input | 1 | Capture event pulse from the edge selector |
| rd_stb | input | 1 | Read strobe for the primary register |
| prim_val | output | CNT_W | Primary capture register, the value software reads |
| sec_val | output | CNT_W | Secondary capture register (holding buffer) |
| overrun | output | 1 | Sticky flag: an untransferred captured value was overwritten |

## Verification
The bench builds the unit with the default 16-bit count. It drives the bus so that slots strictly alternate and each slot's value encodes both its timer and its cycle number, so the bench can tell from any captured value which cycle and which slot it was taken from. The bench sweeps both settings of the source select against events placed in the matching slot and in the other slot. From a fresh reset, each combination runs the full sequence: the start-up shift, holding without a read, a capture and read at the same edge, overrun, and the armed read.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Control flags of the two-stage capture pipeline
    typedef struct packed {
        logic full;   // secondary holds a value not yet moved forward
        logic pvld;   // primary has been loaded at least once
        logic arm;    // read seen, transfer waits for a new capture
        logic ovr;    // sticky overrun
    } cap_flags_t;

    localparam int unsigned NUM_SLOTS = 2;

endpackage

// File: rtl/cap_event_gate.sv
module cap_event_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_a,
    input  logic slot_b,
    input  logic src_sel,
    input  logic evt,
    output logic take
);
    import cap_pkg::*;

    typedef struct packed {
        logic pend;
    } gate_t;

    gate_t gate_q, gate_d;
    logic [NUM_SLOTS-1:0] slot_vec;
    logic                 slot_hit;

    always_comb begin
        slot_vec = {slot_b, slot_a};
        slot_hit = slot_vec[src_sel];
        take     = (evt || gate_q.pend) && slot_hit;
        gate_d   = gate_q;
        if (take) begin
            gate_d.pend = 1'b0;
        end else if (evt) begin
            gate_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

endmodule

// File: rtl/cap_buffer.sv
module cap_buffer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] prim_val,
    output logic [CNT_W-1:0] sec_val,
    output logic             overrun
);
    import cap_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] prim;
        logic [CNT_W-1:0] sec;
        cap_flags_t       fl;
    } buf_t;

    buf_t buf_q, buf_d;
    logic xfer;

    always_comb begin
        buf_d = buf_q;
        // Before the first load, a capture shifts the stages; afterwards a read gates it
        if (buf_q.fl.pvld) begin
            xfer = buf_q.fl.full && (rd_stb || buf_q.fl.arm);
        end else begin
            xfer = buf_q.fl.full && take;
        end

        if (xfer) begin
            buf_d.prim    = buf_q.sec;
            buf_d.fl.pvld = 1'b1;
        end

        if (take) begin
            buf_d.sec     = cnt_in;
            buf_d.fl.full = 1'b1;
        end else if (xfer) begin
            buf_d.fl.full = 1'b0;
        end

        buf_d.fl.arm = buf_q.fl.pvld && (rd_stb || buf_q.fl.arm) && !xfer;
        buf_d.fl.ovr = buf_q.fl.ovr || (take && buf_q.fl.full && !xfer);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign prim_val = buf_q.prim;
    assign sec_val  = buf_q.sec;
    assign overrun  = buf_q.fl.ovr;

endmodule

// File: rtl/cap_unit.sv
module cap_unit #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_bus,
    input  logic             slot_a,
    input  logic             slot_b,
    input  logic             src_sel,
    input  logic             evt,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] prim_val,
    output logic [CNT_W-1:0] sec_val,
    output logic             overrun
);
    logic take;

    cap_event_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_a  (slot_a),
        .slot_b  (slot_b),
        .src_sel (src_sel),
        .evt     (evt),
        .take    (take)
    );

    cap_buffer #(.CNT_W(CNT_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cnt_in   (cnt_bus),
        .rd_stb   (rd_stb),
        .prim_val (prim_val),
        .sec_val  (sec_val),
        .overrun  (overrun)
    );

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_bus,
    input logic             slot_a,
    input logic             slot_b,
    input logic             src_sel,
    input logic             take,
    input logic [CNT_W-1:0] prim_val,
    input logic [CNT_W-1:0] sec_val,
    input logic             overrun
);
    assert_take_in_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (src_sel ? slot_b : slot_a));

    assert_capture_loads_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (sec_val == $past(cnt_bus)));

    assert_sec_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(sec_val));

    assert_prim_from_sec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prim_val) |-> (prim_val == $past(sec_val)));

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

bind cap_unit cap_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_bus  (cnt_bus),
    .slot_a   (slot_a),
    .slot_b   (slot_b),
    .src_sel  (src_sel),
    .take     (take),
    .prim_val (prim_val),
    .sec_val  (sec_val),
    .overrun  (overrun)
);

// File: tb/cap_unit_test.sv
module cap_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_bus = '0;
    logic         slot_a = 1'b1;
    logic         slot_b = 1'b0;
    logic         src_sel = 1'b0;
    logic         evt = 1'b0;
    logic         rd_stb = 1'b0;
    logic [W-1:0] prim_val, sec_val;
    logic         overrun;

    int errors = 0;
    int checks = 0;
    int k = 0;          // cycle index driving the slot pattern
    bit done = 0;

    cap_unit #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_bus(cnt_bus), .slot_a(slot_a),
        .slot_b(slot_b), .src_sel(src_sel), .evt(evt), .rd_stb(rd_stb),
        .prim_val(prim_val), .sec_val(sec_val), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Even cycles carry timer A, odd cycles timer B; value encodes slot and cycle
    function automatic logic [W-1:0] busv(input int kk);
        return (kk % 2 == 0) ? W'(16'h1000 + kk) : W'(16'hA000 + kk);
    endfunction

    function automatic bit hit(input int kk);
        return (kk % 2) == int'(src_sel);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic e, input logic r);
        evt     = e;
        rd_stb  = r;
        slot_a  = (k % 2 == 0);
        slot_b  = (k % 2 != 0);
        cnt_bus = busv(k);
        @(posedge clk);
        @(negedge clk);
        k++;
        evt    = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(0, 0);
        tick(0, 0);
        rst_n = 1'b1;
    endtask

    // Fire one event; in_slot=0 places it in the other timer's slot first
    task automatic fire(input bit in_slot, input logic r, input logic [W-1:0] old_sec,
                        output logic [W-1:0] v);
        if (in_slot) begin
            while (!hit(k)) tick(0, 0);
            v = busv(k);
            tick(1, r);
        end else begin
            while (hit(k)) tick(0, 0);
            tick(1, 0);
            chk("R4 pending event leaves sec", sec_val, old_sec);
            v = busv(k);
            tick(0, r);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v1, v2, v3, v4, v5;
        @(negedge clk);
        for (int sel = 0; sel < 2; sel++) begin
            for (int ph = 0; ph < 2; ph++) begin
                src_sel = sel[0];
                do_reset();
                chk("R1 prim after reset", prim_val, '0);
                chk("R1 sec after reset", sec_val, '0);
                chk("R1 overrun after reset", {15'd0, overrun}, 16'd0);

                // start-up: first capture into secondary only
                fire(ph[0], 1'b1, '0, v1);
                chk("R2 R3 first capture value", sec_val, v1);
                chk("R2 slot of capture", {15'd0, v1[15]}, {15'd0, sel[0]});
                chk("R5 prim after one capture", prim_val, '0);
                repeat (3) tick(0, 0);
                chk("R3 sec holds while idle", sec_val, v1);

                fire(ph[0], 1'b0, v1, v2);
                chk("R5 prim after two captures", prim_val, v1);
                chk("R5 sec after two captures", sec_val, v2);
                chk("R5 no overrun on start-up shift", {15'd0, overrun}, 16'd0);

                // capture and read at the same edge
                fire(ph[0], 1'b1, v2, v3);
                chk("R9 prim takes old sec", prim_val, v2);
                chk("R9 sec takes new count", sec_val, v3);
                chk("R9 no overrun", {15'd0, overrun}, 16'd0);

                // capture without read: overwrite and overrun
                fire(ph[0], 1'b0, v3, v4);
                chk("R6 prim held without read", prim_val, v2);
                chk("R8 sec overwritten", sec_val, v4);
                chk("R8 overrun set", {15'd0, overrun}, 16'd1);

                // read with a held value
                tick(0, 1);
                chk("R7 read transfers sec", prim_val, v4);

                // read with nothing held arms the transfer
                tick(0, 1);
                repeat (2) tick(0, 0);
                chk("R7 armed read leaves prim", prim_val, v4);
                fire(ph[0], 1'b0, v4, v5);
                chk("R7 armed: sec loaded", sec_val, v5);
                chk("R7 armed: prim before transfer", prim_val, v4);
                tick(0, 0);
                chk("R7 armed transfer after capture", prim_val, v5);
                chk("R8 overrun sticky", {15'd0, overrun}, 16'd1);
            end
        end
        do_reset();
        chk("R1 overrun cleared by reset", {15'd0, overrun}, 16'd0);
        chk("R1 prim cleared by reset", prim_val, '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule